// File: doc/BRIEF.md
# Boot Memory Remap Decoder

This block decodes a 32-bit bus address into one of three targets: the on-chip program memory, the on-chip SRAM, or nothing at all. The bottom 64 KB of the address space is a switchable alias. Out of reset it shows the program memory, so the reset handler and exception vectors at 0x00000000 to 0x00000020 are fetched from program memory. Software can set a single control bit so that the same window shows the SRAM instead. This lets exception code run from faster storage. The two memories stay reachable at their fixed bases whatever the control bit holds.

A bus access is presented as a valid strobe with an address. One clock later the block drives exactly one of three selects: program memory, SRAM or unmapped. It also drives the offset into the selected memory and a read-data mux that returns zero for unmapped accesses. The control bit has a one-bit write port and a read port. A write takes effect from the access that follows the write cycle. An access in the same cycle as the write still uses the old setting.

Top module: `remap_decoder`

## Requirements
- R1: While reset is asserted, and after any reset, the remap bit is 0 and all three selects are low. An access to the low window after a reset selects program memory, even if the bit was 1 before the reset.
- R2: With the remap bit at 0, an address in 0x00000000–0x0000FFFF selects program memory with offset equal to address bits 15:0.
- R3: With the remap bit at 1, an address in 0x00000000–0x0000FFFF selects SRAM with offset equal to address bits 12:0. The window therefore repeats every 8 KB (0x2004 gives offset 0x0004, 0xFFFF gives offset 0x1FFF).
- R4: Writing 0 to the remap bit after it was 1 makes the low window select program memory again.
- R5: Addresses 0x00040000–0x00041FFF select SRAM with offset equal to address bits 12:0, whatever the remap bit holds.
- R6: Addresses 0x00080000–0x0008FFFF select program memory with offset equal to address bits 15:0, whatever the remap bit holds.
- R7: Every other address (for example 0x00010000, 0x0003FFFF, 0x00042000, 0x0007FFFC, 0x00090000, 0xFFFFFFFF) raises the unmapped select. For such an access, bus read data is zero.
- R8: An access presented in the same cycle as a remap write is decoded with the old bit value. The next access uses the new value.
- R9: The control read port returns the remap bit in bit 0 and zero in bits 31:1. The bit changes only on a write.
- R10: Selects and offsets are registered. They appear in the cycle after the access strobe, with exactly one select high. In a cycle with no access, all selects are low and offsets are zero.
- R11: Bus read data equals the program memory read data when program memory is selected, the SRAM read data when SRAM is selected, and zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset (any reset source) |
| accValid | input | 1 | Bus access strobe, one cycle per access |
| accAddr | input | 32 | Bus byte address |
| cfgWrEn | input | 1 | Remap bit write enable |
| cfgWrBit | input | 1 | Value written to the remap bit |
| cfgRdData | output | 32 | Control readback, remap bit in position 0 |
| progRdData | input | 32 | Read data from program memory |
| sramRdData | input | 32 | Read data from SRAM |
| progSel | output | 1 | Program memory chip select |
| progOffset | output | 16 | Byte offset into program memory |
| sramSel | output | 1 | SRAM chip select |
| sramOffset | output | 13 | Byte offset into SRAM |
| unmappedSel | output | 1 | Access hit no decoded region |
| busRdData | output | 32 | Read data returned to the bus |

## Verification
The bench builds the block with its default parameters: a 64 KB program memory at 0x00080000, an 8 KB SRAM at 0x00040000, and a low window as large as the program memory. With these sizes the SRAM alias repeats eight times inside the window, so the wrap at offset 0x1FFF and the return to 0x0000 can be reached by direct addresses. The addresses one byte past each region and one word below each base can be reached the same way. The remap write is also placed in the same cycle as an access, to show which value the decode uses.

// File: rtl/remap_pkg.sv
package remap_pkg;

  typedef enum logic [1:0] {
    RG_NONE = 2'd0,
    RG_PROG = 2'd1,
    RG_SRAM = 2'd2
  } regionE;

  typedef struct packed {
    logic capture;   // latch a new access this cycle
    logic remapSel;  // low window shows SRAM when set
  } strobeT;

endpackage

// File: rtl/remap_region_match.sv
module remap_region_match #(
  parameter int ADDR_W = 32,
  parameter int AW = 16,
  parameter logic [ADDR_W-1:0] BASE = '0
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  localparam int TAG_W = ADDR_W - AW;
  localparam logic [TAG_W-1:0] BASE_TAG = BASE[ADDR_W-1:AW];

  always_comb begin
    hit = (addr[ADDR_W-1:AW] == BASE_TAG);
  end
endmodule

// File: rtl/remap_ctrl.sv
module remap_ctrl
  import remap_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accValid,
  input  logic              cfgWrEn,
  input  logic              cfgWrBit,
  output logic [DATA_W-1:0] cfgRdData,
  output strobeT            strobe
);
  logic remapQ;

  // The bit flips at the clock edge, so an access sampled at that edge
  // still sees the old value.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) remapQ <= 1'b0;
    else if (cfgWrEn) remapQ <= cfgWrBit;
  end

  always_comb begin
    strobe.capture  = accValid;
    strobe.remapSel = remapQ;
    cfgRdData       = {{(DATA_W-1){1'b0}}, remapQ};
  end

  a_r1_reset_clears: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !remapQ);

  a_r9_hold_without_write: assert property (@(posedge clk) disable iff (!rstN)
    !cfgWrEn |=> $stable(remapQ));

  a_r8_write_lands_next: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrEn |=> (cfgRdData[0] == $past(cfgWrBit)));

endmodule

// File: rtl/remap_datapath.sv
module remap_datapath
  import remap_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int PROG_AW = 16,
  parameter int SRAM_AW = 13,
  parameter logic [ADDR_W-1:0] PROG_BASE = 32'h0008_0000,
  parameter logic [ADDR_W-1:0] SRAM_BASE = 32'h0004_0000
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobeT             strobe,
  input  logic [ADDR_W-1:0]  accAddr,
  input  logic [DATA_W-1:0]  progRdData,
  input  logic [DATA_W-1:0]  sramRdData,
  output logic               progSel,
  output logic [PROG_AW-1:0] progOffset,
  output logic               sramSel,
  output logic [SRAM_AW-1:0] sramOffset,
  output logic               unmappedSel,
  output logic [DATA_W-1:0]  busRdData
);
  // The window is as large as the program memory; the SRAM alias repeats in it.
  localparam int WIN_AW = PROG_AW;
  localparam int N_REG = 3;
  localparam int IDX_WIN = 0;
  localparam int IDX_SRAM = 1;
  localparam int IDX_PROG = 2;

  logic [N_REG-1:0] hitVec;

  generate
    for (genvar i = 0; i < N_REG; i++) begin : g_match
      localparam int RAW = (i == IDX_SRAM) ? SRAM_AW : ((i == IDX_PROG) ? PROG_AW : WIN_AW);
      localparam logic [ADDR_W-1:0] RBASE =
        (i == IDX_SRAM) ? SRAM_BASE : ((i == IDX_PROG) ? PROG_BASE : '0);
      remap_region_match #(
        .ADDR_W(ADDR_W),
        .AW(RAW),
        .BASE(RBASE)
      ) u_match (
        .addr(accAddr),
        .hit (hitVec[i])
      );
    end
  endgenerate

  regionE nxtRegion;
  logic [PROG_AW-1:0] nxtProgOff;
  logic [SRAM_AW-1:0] nxtSramOff;

  always_comb begin
    if (hitVec[IDX_WIN]) nxtRegion = strobe.remapSel ? RG_SRAM : RG_PROG;
    else if (hitVec[IDX_SRAM]) nxtRegion = RG_SRAM;
    else if (hitVec[IDX_PROG]) nxtRegion = RG_PROG;
    else nxtRegion = RG_NONE;
    nxtProgOff = (nxtRegion == RG_PROG) ? accAddr[PROG_AW-1:0] : '0;
    nxtSramOff = (nxtRegion == RG_SRAM) ? accAddr[SRAM_AW-1:0] : '0;
  end

  regionE regionQ;
  logic validQ;
  logic [PROG_AW-1:0] progOffQ;
  logic [SRAM_AW-1:0] sramOffQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ   <= 1'b0;
      regionQ  <= RG_NONE;
      progOffQ <= '0;
      sramOffQ <= '0;
    end else if (strobe.capture) begin
      validQ   <= 1'b1;
      regionQ  <= nxtRegion;
      progOffQ <= nxtProgOff;
      sramOffQ <= nxtSramOff;
    end else begin
      validQ   <= 1'b0;
      regionQ  <= RG_NONE;
      progOffQ <= '0;
      sramOffQ <= '0;
    end
  end

  always_comb begin
    progSel     = validQ && (regionQ == RG_PROG);
    sramSel     = validQ && (regionQ == RG_SRAM);
    unmappedSel = validQ && (regionQ == RG_NONE);
    progOffset  = progOffQ;
    sramOffset  = sramOffQ;
    if (progSel) busRdData = progRdData;
    else if (sramSel) busRdData = sramRdData;
    else busRdData = '0;
  end

  a_r10_one_select: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> ($countones({progSel, sramSel, unmappedSel}) == 1));

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> !(progSel || sramSel || unmappedSel));

  a_r5_sram_fixed: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && hitVec[IDX_SRAM]) |=> sramSel);

  a_r6_prog_fixed: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && hitVec[IDX_PROG]) |=> progSel);

  a_r7_unmapped_zero: assert property (@(posedge clk) disable iff (!rstN)
    unmappedSel |-> (busRdData == '0));

  a_r2_window_prog: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && hitVec[IDX_WIN] && !strobe.remapSel) |=> progSel);

  a_r3_window_sram: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && hitVec[IDX_WIN] && strobe.remapSel) |=> sramSel);

endmodule

// File: rtl/remap_decoder.sv
module remap_decoder
  import remap_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int PROG_AW = 16,
  parameter int SRAM_AW = 13,
  parameter logic [ADDR_W-1:0] PROG_BASE = 32'h0008_0000,
  parameter logic [ADDR_W-1:0] SRAM_BASE = 32'h0004_0000
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               accValid,
  input  logic [ADDR_W-1:0]  accAddr,
  input  logic               cfgWrEn,
  input  logic               cfgWrBit,
  output logic [DATA_W-1:0]  cfgRdData,
  input  logic [DATA_W-1:0]  progRdData,
  input  logic [DATA_W-1:0]  sramRdData,
  output logic               progSel,
  output logic [PROG_AW-1:0] progOffset,
  output logic               sramSel,
  output logic [SRAM_AW-1:0] sramOffset,
  output logic               unmappedSel,
  output logic [DATA_W-1:0]  busRdData
);
  strobeT strobe;

  remap_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .accValid (accValid),
    .cfgWrEn  (cfgWrEn),
    .cfgWrBit (cfgWrBit),
    .cfgRdData(cfgRdData),
    .strobe   (strobe)
  );

  remap_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .PROG_AW(PROG_AW),
    .SRAM_AW(SRAM_AW),
    .PROG_BASE(PROG_BASE),
    .SRAM_BASE(SRAM_BASE)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .accAddr    (accAddr),
    .progRdData (progRdData),
    .sramRdData (sramRdData),
    .progSel    (progSel),
    .progOffset (progOffset),
    .sramSel    (sramSel),
    .sramOffset (sramOffset),
    .unmappedSel(unmappedSel),
    .busRdData  (busRdData)
  );
endmodule

// File: tb/remap_decoder_bench.sv
module remap_decoder_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic accValid = 1'b0;
  logic [31:0] accAddr = '0;
  logic cfgWrEn = 1'b0;
  logic cfgWrBit = 1'b0;
  logic [31:0] cfgRdData;
  logic [31:0] progRdData = 32'hC0DE_0001;
  logic [31:0] sramRdData = 32'h5A5A_0002;
  logic progSel, sramSel, unmappedSel;
  logic [15:0] progOffset;
  logic [12:0] sramOffset;
  logic [31:0] busRdData;

  always #4 clk = ~clk;

  remap_decoder u_remap_decoder (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accAddr(accAddr),
    .cfgWrEn(cfgWrEn), .cfgWrBit(cfgWrBit), .cfgRdData(cfgRdData),
    .progRdData(progRdData), .sramRdData(sramRdData),
    .progSel(progSel), .progOffset(progOffset), .sramSel(sramSel),
    .sramOffset(sramOffset), .unmappedSel(unmappedSel), .busRdData(busRdData)
  );

  typedef struct {
    logic [2:0]  sels;   // {prog, sram, unmapped}
    logic [15:0] po;
    logic [12:0] so;
    logic [31:0] rd;
    string       req;
  } expT;

  expT expQ[$];
  int nChecks = 0;
  int nFails = 0;
  logic modelRemap = 1'b0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic expT model(logic [31:0] a, logic rm, string req);
    expT e;
    e.req = req; e.po = '0; e.so = '0;
    if (a[31:16] == 16'h0 && !rm) begin
      e.sels = 3'b100; e.po = a[15:0]; e.rd = progRdData;
    end else if (a[31:16] == 16'h0 && rm) begin
      e.sels = 3'b010; e.so = a[12:0]; e.rd = sramRdData;
    end else if (a[31:13] == 19'h20) begin
      e.sels = 3'b010; e.so = a[12:0]; e.rd = sramRdData;
    end else if (a[31:16] == 16'h8) begin
      e.sels = 3'b100; e.po = a[15:0]; e.rd = progRdData;
    end else begin
      e.sels = 3'b001; e.rd = '0;
    end
    return e;
  endfunction

  // Driver: every task starts at a falling edge and drives all inputs.
  task automatic access(logic [31:0] a, string req);
    @(negedge clk);
    accValid = 1'b1; accAddr = a; cfgWrEn = 1'b0;
    expQ.push_back(model(a, modelRemap, req));
  endtask

  task automatic accessWrite(logic [31:0] a, logic b, string req);
    @(negedge clk);
    accValid = 1'b1; accAddr = a; cfgWrEn = 1'b1; cfgWrBit = b;
    expQ.push_back(model(a, modelRemap, req));
    modelRemap = b;
  endtask

  task automatic writeBit(logic b);
    @(negedge clk);
    accValid = 1'b0; cfgWrEn = 1'b1; cfgWrBit = b;
    modelRemap = b;
  endtask

  task automatic idle();
    @(negedge clk);
    accValid = 1'b0; cfgWrEn = 1'b0;
  endtask

  // Monitor: outputs settle just after the edge that captured the access.
  always @(posedge clk) begin
    #2;
    if (expQ.size() > 0) begin
      expT e;
      e = expQ.pop_front();
      chk({e.req, " selects"}, {29'b0, progSel, sramSel, unmappedSel}, {29'b0, e.sels});
      chk({e.req, " progOffset"}, {16'b0, progOffset}, {16'b0, e.po});
      chk({e.req, " sramOffset"}, {19'b0, sramOffset}, {19'b0, e.so});
      chk({e.req, " busRdData (R11)"}, busRdData, e.rd);
    end
  end

  initial begin
    #1_000_000;
    nFails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset cfgRdData", cfgRdData, 32'h0);
    chk("R1 reset selects", {29'b0, progSel, sramSel, unmappedSel}, 32'h0);
    rstN = 1'b1;

    access(32'h0000_0010, "R2 vector");
    access(32'h0000_FFFC, "R2 window top");
    access(32'h0004_0000, "R5 sram base");
    access(32'h0004_1FFF, "R5 sram last");
    access(32'h0008_0020, "R6 prog");
    access(32'h0008_FFFF, "R6 prog last");
    access(32'h0001_0000, "R7 past window");
    access(32'h0003_FFFF, "R7 below sram");
    access(32'h0004_2000, "R7 past sram");
    access(32'h0007_FFFC, "R7 below prog");
    access(32'h0009_0000, "R7 past prog");
    access(32'hFFFF_FFFF, "R7 top");
    idle();
    idle();
    chk("R10 idle selects", {29'b0, progSel, sramSel, unmappedSel}, 32'h0);
    chk("R10 idle offsets", {progOffset, 3'b0, sramOffset}, 32'h0);

    accessWrite(32'h0000_0020, 1'b1, "R8 same-cycle write");
    access(32'h0000_0020, "R3 after write");
    access(32'h0000_2004, "R3 wrap");
    access(32'h0000_FFFF, "R3 wrap top");
    access(32'h0004_0100, "R5 remapped");
    access(32'h0008_0000, "R6 remapped");
    access(32'h0001_0000, "R7 remapped");
    idle();
    chk("R9 readback one", cfgRdData, 32'h1);
    idle();
    chk("R9 readback held", cfgRdData, 32'h1);

    writeBit(1'b0);
    idle();
    chk("R9 readback zero", cfgRdData, 32'h0);
    access(32'h0000_2004, "R4 restored");
    access(32'h0004_0004, "R5 restored");

    writeBit(1'b1);
    idle();
    chk("R9 readback set again", cfgRdData, 32'h1);
    idle();
    rstN = 1'b0;
    modelRemap = 1'b0;
    #1;
    chk("R1 mid-run reset cfgRdData", cfgRdData, 32'h0);
    @(negedge clk);
    rstN = 1'b1;
    access(32'h0000_0000, "R1 window after reset");
    idle();
    idle();
    idle();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule